// File: doc/BRIEF.md
# PCIe TLP Trace Capture

This block watches the receive and transmit beat streams of a PCIe endpoint's user-side interface and logs every valid beat into an on-chip circular trace buffer. Each logged entry carries the following:

- the direction and a kind marker (request start, response start or continuation);
- the byte enables, the BAR hit number, the start and end flags and the 128-bit data beat;
- a 64-bit free-running timestamp counted in user clock cycles;
- the number of cycles since the previously logged entry.

When a receive beat and a transmit beat arrive in the same cycle, both are logged. The receive beat always comes first, and the transmit beat follows it with a zero delta. The delta saturates instead of wrapping. Once the buffer is full, new entries overwrite the oldest ones and a sticky wrap flag is raised.

Software or a drain engine pulls entries, oldest first, through a valid/ready read port. A capture enable input freezes logging. A clear input empties the buffer, drops the wrap flag and forgets the delta reference, so the next entry starts again at delta 0.

Top module: `tlp_trace_capture`

## Requirements
- R1: Each entry's `rd_ts` is the value of a 64-bit counter that is zero at reset and rises by one on every clock edge, sampled in the cycle the beat was presented.
- R2: Each entry copies the beat's byte enables, BAR hit, SOF, EOF and data unchanged. `rd_dir` is 0 for a receive beat and 1 for a transmit beat.
- R3: `rd_kind` is 2'b00 (continuation) when SOF is 0. When SOF is 1, it is 2'b01 (request start) if the beat's `*_cpl` input is 0, and 2'b10 (response start) if it is 1.
- R4: `rd_delta` is the number of cycles between this entry's beat and the previous logged entry's beat. The first entry after reset has delta 0.
- R5: When both streams present a beat in one cycle, the receive entry is stored before the transmit entry. Both entries share one timestamp, and the transmit entry has delta 0.
- R6: A gap longer than 2^DLT_W-1 cycles gives a delta of exactly 2^DLT_W-1.
- R7: The buffer holds DEPTH entries. A push into a full buffer discards the oldest entry and sets `wrapped`, which stays at 1 until a clear.
- R8: `rd_valid` is 1 while the buffer holds an entry, and `rd_valid && rd_ready` removes the oldest entry. A removal in the same cycle as two pushes loses no entry.
- R9: While `cap_en` is 0, beats are not logged and do not move the delta reference.
- R10: `clear` empties the buffer, drops `wrapped` and resets the delta reference, so the next logged entry has delta 0. Beats presented in the clear cycle or the cycle before it are discarded.
- R11: After reset, `rd_valid` and `wrapped` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCIe user clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture enable |
| clear | input | 1 | Synchronous buffer and delta-reference clear |
| rx_vld | input | 1 | Receive beat valid |
| rx_sof | input | 1 | Receive beat starts a TLP |
| rx_eof | input | 1 | Receive beat ends a TLP |
| rx_cpl | input | 1 | Receive TLP is a response |
| rx_be | input | 16 | Receive byte enables |
| rx_bar | input | 3 | Receive BAR hit |
| rx_data | input | 128 | Receive data beat |
| tx_vld | input | 1 | Transmit beat valid |
| tx_sof | input | 1 | Transmit beat starts a TLP |
| tx_eof | input | 1 | Transmit beat ends a TLP |
| tx_cpl | input | 1 | Transmit TLP is a response |
| tx_be | input | 16 | Transmit byte enables |
| tx_bar | input | 3 | Transmit BAR hit |
| tx_data | input | 128 | Transmit data beat |
| rd_ready | input | 1 | Reader accepts the offered entry |
| rd_valid | output | 1 | An entry is offered |
| rd_dir | output | 1 | Direction, 0 receive, 1 transmit |
| rd_kind | output | 2 | Entry kind code |
| rd_be | output | 16 | Logged byte enables |
| rd_bar | output | 3 | Logged BAR hit |
| rd_sof | output | 1 | Logged SOF |
| rd_eof | output | 1 | Logged EOF |
| rd_data | output | 128 | Logged data beat |
| rd_ts | output | 64 | Logged timestamp |
| rd_delta | output | DLT_W | Cycles since previous entry |
| wrapped | output | 1 | Sticky overwrite flag |

## Verification
The bench builds the block with DEPTH=8 and DLT_W=4. With only eight slots, a burst of about a dozen beats overflows the buffer, so the overwrite order and the sticky wrap flag can be checked. A four-bit delta saturates at 15, so an idle gap of 30 cycles checks the saturation limit. The bench also holds the reader active during paired receive/transmit bursts, so removals coincide with double pushes.

// File: rtl/ttr_pkg.sv
package ttr_pkg;
    localparam int BE_W   = 16;
    localparam int DATA_W = 128;
    localparam int TS_W   = 64;
    localparam int BAR_W  = 3;

    typedef enum logic [1:0] {
        KIND_CONT = 2'b00,
        KIND_REQ  = 2'b01,
        KIND_RSP  = 2'b10
    } kind_e;

    typedef struct packed {
        logic              dir;
        kind_e             kind;
        logic [BE_W-1:0]   be;
        logic [BAR_W-1:0]  bar;
        logic              sof;
        logic              eof;
        logic [DATA_W-1:0] data;
        logic [TS_W-1:0]   ts;
    } beat_t;

    function automatic kind_e classify(input logic sof, input logic cpl);
        if (!sof)     return KIND_CONT;
        else if (cpl) return KIND_RSP;
        else          return KIND_REQ;
    endfunction
endpackage

// File: rtl/ttr_stamp.sv
module ttr_stamp
    import ttr_pkg::*;
#(
    parameter int DLT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic             clear,
    input  logic             rx_vld,
    input  beat_t            rx_b,
    input  logic             tx_vld,
    input  beat_t            tx_b,
    output logic             st_v0,
    output logic             st_v1,
    output beat_t            st_e0,
    output beat_t            st_e1,
    output logic [DLT_W-1:0] st_d0
);
    localparam logic [TS_W-1:0] DMAX = TS_W'((65'd1 << DLT_W) - 65'd1);

    typedef struct packed {
        logic [TS_W-1:0]  ts;
        logic [TS_W-1:0]  last;
        logic             have_ref;
        logic             v0;
        logic             v1;
        beat_t            e0;
        beat_t            e1;
        logic [DLT_W-1:0] d0;
    } stamp_t;

    stamp_t s_d, s_q;
    logic [TS_W-1:0] gap;
    logic take_rx, take_tx;

    always_comb begin
        s_d    = s_q;
        s_d.ts = s_q.ts + 1'b1;
        s_d.v0 = 1'b0;
        s_d.v1 = 1'b0;
        gap     = s_q.ts - s_q.last;
        take_rx = cap_en && !clear && rx_vld;
        take_tx = cap_en && !clear && tx_vld;
        if (clear) begin
            s_d.have_ref = 1'b0;
        end else if (take_rx || take_tx) begin
            s_d.v0       = 1'b1;
            s_d.v1       = take_rx && take_tx;
            s_d.e0       = take_rx ? rx_b : tx_b;
            s_d.e0.ts    = s_q.ts;
            s_d.e1       = tx_b;
            s_d.e1.ts    = s_q.ts;
            s_d.d0       = !s_q.have_ref ? '0 :
                           (gap > DMAX) ? '1 : gap[DLT_W-1:0];
            s_d.last     = s_q.ts;
            s_d.have_ref = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign st_v0 = s_q.v0;
    assign st_v1 = s_q.v1;
    assign st_e0 = s_q.e0;
    assign st_e1 = s_q.e1;
    assign st_d0 = s_q.d0;

    // R5
    rx_before_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_v1 |-> (!st_e0.dir && st_e1.dir && st_e0.ts == st_e1.ts));

    // R5
    pair_needs_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_v1 |-> st_v0);

    // R1
    ts_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && cap_en && !clear) |=> (st_v0 && st_e0.ts == $past(s_q.ts)));
endmodule

// File: rtl/ttr_ring.sv
module ttr_ring
    import ttr_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int DLT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             v0,
    input  logic             v1,
    input  beat_t            e0,
    input  beat_t            e1,
    input  logic [DLT_W-1:0] d0,
    input  logic             rd_ready,
    output logic             rd_valid,
    output beat_t            rd_ent,
    output logic [DLT_W-1:0] rd_dlt,
    output logic             wrapped
);
    localparam int AW = $clog2(DEPTH);
    localparam int SW = AW + 2;

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [AW:0]   cnt;
        logic          wrap;
    } ring_t;

    ring_t r_d, r_q;
    beat_t            mem_q [DEPTH];
    logic [DLT_W-1:0] dlt_q [DEPTH];
    logic [1:0]       push;
    logic             pop;
    logic [SW-1:0]    sum, drop;

    assign rd_valid = (r_q.cnt != '0);
    assign rd_ent   = mem_q[r_q.rd];
    assign rd_dlt   = dlt_q[r_q.rd];
    assign wrapped  = r_q.wrap;

    always_comb begin
        r_d  = r_q;
        push = {1'b0, v0} + {1'b0, v1};
        pop  = rd_valid && rd_ready;
        sum  = SW'(r_q.cnt) + SW'(push) - SW'(pop);
        drop = '0;
        if (clear) begin
            r_d = '0;
        end else begin
            r_d.wr = r_q.wr + AW'(push);
            if (sum > SW'(DEPTH)) begin
                drop     = sum - SW'(DEPTH);
                r_d.rd   = r_q.rd + AW'(pop) + AW'(drop);
                r_d.cnt  = (AW+1)'(DEPTH);
                r_d.wrap = 1'b1;
            end else begin
                r_d.rd  = r_q.rd + AW'(pop);
                r_d.cnt = sum[AW:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (!clear && v0) begin
            mem_q[r_q.wr] <= e0;
            dlt_q[r_q.wr] <= d0;
        end
        if (!clear && v1) begin
            mem_q[r_q.wr + AW'(1)] <= e1;
            dlt_q[r_q.wr + AW'(1)] <= '0;
        end
    end

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= (AW+1)'(DEPTH));

    // R7
    wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrapped && !clear) |=> wrapped);

    // R10
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!rd_valid && !wrapped));

    // R8
    pop_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && !v0 && !clear) |=> (r_q.cnt == $past(r_q.cnt) - 1'b1));
endmodule

// File: rtl/tlp_trace_capture.sv
module tlp_trace_capture
    import ttr_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int DLT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              clear,
    input  logic              rx_vld,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_cpl,
    input  logic [BE_W-1:0]   rx_be,
    input  logic [BAR_W-1:0]  rx_bar,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              tx_vld,
    input  logic              tx_sof,
    input  logic              tx_eof,
    input  logic              tx_cpl,
    input  logic [BE_W-1:0]   tx_be,
    input  logic [BAR_W-1:0]  tx_bar,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic              rd_dir,
    output logic [1:0]        rd_kind,
    output logic [BE_W-1:0]   rd_be,
    output logic [BAR_W-1:0]  rd_bar,
    output logic              rd_sof,
    output logic              rd_eof,
    output logic [DATA_W-1:0] rd_data,
    output logic [TS_W-1:0]   rd_ts,
    output logic [DLT_W-1:0]  rd_delta,
    output logic              wrapped
);
    beat_t            rx_b, tx_b, st_e0, st_e1, rd_ent;
    logic             st_v0, st_v1;
    logic [DLT_W-1:0] st_d0;

    always_comb begin
        rx_b = '{dir: 1'b0, kind: classify(rx_sof, rx_cpl), be: rx_be, bar: rx_bar,
                 sof: rx_sof, eof: rx_eof, data: rx_data, ts: '0};
        tx_b = '{dir: 1'b1, kind: classify(tx_sof, tx_cpl), be: tx_be, bar: tx_bar,
                 sof: tx_sof, eof: tx_eof, data: tx_data, ts: '0};
    end

    ttr_stamp #(.DLT_W(DLT_W)) u_stamp (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .clear(clear),
        .rx_vld(rx_vld), .rx_b(rx_b), .tx_vld(tx_vld), .tx_b(tx_b),
        .st_v0(st_v0), .st_v1(st_v1), .st_e0(st_e0), .st_e1(st_e1), .st_d0(st_d0)
    );

    ttr_ring #(.DEPTH(DEPTH), .DLT_W(DLT_W)) u_ring (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .v0(st_v0), .v1(st_v1), .e0(st_e0), .e1(st_e1), .d0(st_d0),
        .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_ent(rd_ent),
        .rd_dlt(rd_delta), .wrapped(wrapped)
    );

    assign rd_dir  = rd_ent.dir;
    assign rd_kind = rd_ent.kind;
    assign rd_be   = rd_ent.be;
    assign rd_bar  = rd_ent.bar;
    assign rd_sof  = rd_ent.sof;
    assign rd_eof  = rd_ent.eof;
    assign rd_data = rd_ent.data;
    assign rd_ts   = rd_ent.ts;
endmodule

// File: tb/tlp_trace_capture_test.sv
module tlp_trace_capture_test;
    localparam int DEPTH = 8;
    localparam int DLT_W = 4;
    localparam int DMAX  = (1 << DLT_W) - 1;

    typedef struct {
        bit          dir;
        bit [1:0]    kind;
        bit [15:0]   be;
        bit [2:0]    bar;
        bit          sof, eof;
        bit [127:0]  data;
        longint      ts;
        int          delta;
        string       dtag;
    } exp_t;

    logic clk = 0, rst_n = 0, cap_en = 1, clear = 0;
    logic rx_vld = 0, rx_sof = 0, rx_eof = 0, rx_cpl = 0;
    logic tx_vld = 0, tx_sof = 0, tx_eof = 0, tx_cpl = 0;
    logic [15:0] rx_be = 0, tx_be = 0;
    logic [2:0] rx_bar = 0, tx_bar = 0;
    logic [127:0] rx_data = 0, tx_data = 0;
    logic drain = 0;
    logic rd_valid, rd_dir, rd_sof, rd_eof, wrapped;
    logic [1:0] rd_kind;
    logic [15:0] rd_be;
    logic [2:0] rd_bar;
    logic [127:0] rd_data;
    logic [63:0] rd_ts;
    logic [DLT_W-1:0] rd_delta;

    int n_chk = 0, n_bad = 0, sd = 1;
    longint cyc = 0, last_cyc = 0;
    bit have_ref = 0, done = 0;
    string dtag = "R4";
    exp_t q[$];

    always #2 clk = ~clk;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    tlp_trace_capture #(.DEPTH(DEPTH), .DLT_W(DLT_W)) uut (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .clear(clear),
        .rx_vld(rx_vld), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_cpl(rx_cpl),
        .rx_be(rx_be), .rx_bar(rx_bar), .rx_data(rx_data),
        .tx_vld(tx_vld), .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_cpl(tx_cpl),
        .tx_be(tx_be), .tx_bar(tx_bar), .tx_data(tx_data),
        .rd_ready(drain), .rd_valid(rd_valid), .rd_dir(rd_dir), .rd_kind(rd_kind),
        .rd_be(rd_be), .rd_bar(rd_bar), .rd_sof(rd_sof), .rd_eof(rd_eof),
        .rd_data(rd_data), .rd_ts(rd_ts), .rd_delta(rd_delta), .wrapped(wrapped)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit [1:0] kind_of(input bit sof, input bit cpl);
        return !sof ? 2'b00 : (cpl ? 2'b10 : 2'b01);
    endfunction

    // Scoreboard monitor: compares every entry the reader accepts
    always @(negedge clk) begin
        if (rst_n && rd_valid && drain) begin
            if (q.size() == 0) begin
                chk(0, "R8", "unexpected entry", rd_ts, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(rd_dir == e.dir, "R2", "dir", rd_dir, e.dir);
                chk(rd_kind == e.kind, "R3", "kind", rd_kind, e.kind);
                chk(rd_be == e.be && rd_bar == e.bar, "R2", "be/bar",
                    {rd_be, rd_bar}, {e.be, e.bar});
                chk(rd_sof == e.sof && rd_eof == e.eof, "R2", "sof/eof",
                    {rd_sof, rd_eof}, {e.sof, e.eof});
                chk(rd_data == e.data, "R2", "data", rd_data, e.data);
                chk(rd_ts == 64'(e.ts), "R1", "timestamp", rd_ts, e.ts);
                chk(int'(rd_delta) == e.delta, e.dtag, "delta", rd_delta, e.delta);
            end
        end
    end

    // Drive one cycle of beats (held until the next step) and record the expectation
    task automatic step(input bit rv, input bit tv, input bit sof, input bit eof, input bit cpl);
        exp_t a, b;
        longint gap;
        @(posedge clk); #1;
        sd++;
        rx_vld = rv; tx_vld = tv;
        rx_sof = sof; rx_eof = eof; rx_cpl = cpl;
        tx_sof = sof; tx_eof = eof; tx_cpl = !cpl;
        rx_be = 16'hFFFF ^ 16'(sd); tx_be = 16'h0F0F ^ 16'(sd);
        rx_bar = 3'(sd); tx_bar = 3'(sd + 3);
        rx_data = {4{32'hA5000000 | sd}}; tx_data = {4{32'h5A000000 | sd}};
        if (cap_en && (rv || tv)) begin
            gap = cyc - last_cyc;
            a.dir = !rv; a.sof = sof; a.eof = eof; a.ts = cyc;
            a.kind = kind_of(sof, rv ? cpl : !cpl);
            a.be = rv ? rx_be : tx_be; a.bar = rv ? rx_bar : tx_bar;
            a.data = rv ? rx_data : tx_data;
            a.delta = !have_ref ? 0 : (gap > DMAX ? DMAX : int'(gap));
            a.dtag = (have_ref && gap > DMAX) ? "R6" : dtag;
            q.push_back(a);
            if (rv && tv) begin
                b.dir = 1; b.sof = sof; b.eof = eof; b.ts = cyc;
                b.kind = kind_of(sof, !cpl); b.be = tx_be; b.bar = tx_bar;
                b.data = tx_data; b.delta = 0; b.dtag = "R5";
                q.push_back(b);
            end
            last_cyc = cyc; have_ref = 1; dtag = "R4";
            if (!drain) while (q.size() > DEPTH) void'(q.pop_front());
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            rx_vld = 0; tx_vld = 0;
        end
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 100 && (q.size() != 0 || rd_valid); i++) @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            chk(0, "R8", "watchdog expired", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #9 rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(rd_valid == 0, "R11", "rd_valid after reset", rd_valid, 0);
        chk(wrapped == 0, "R11", "wrapped after reset", wrapped, 0);
        drain = 1;

        // R3 request start, response start, multi-beat continuation
        step(1, 0, 1, 1, 0); idle(3);
        step(0, 1, 1, 1, 0); idle(2);
        step(1, 0, 1, 0, 1); step(1, 0, 0, 0, 1); step(1, 0, 0, 1, 1); idle(1);
        step(0, 1, 1, 0, 1); step(0, 1, 0, 1, 1); idle(4);

        // R5 / R8 same-cycle pairs while the reader pops
        step(1, 1, 1, 0, 0); step(1, 1, 0, 0, 0); step(1, 1, 0, 0, 0); step(1, 1, 0, 1, 0);
        idle(2);
        wait_empty();
        chk(q.size() == 0 && !rd_valid, "R8", "all paired entries delivered", q.size(), 0);

        // R6 saturated delta after a long gap
        idle(30);
        step(1, 0, 1, 1, 0); idle(2);

        // R9 disabled capture
        cap_en = 0;
        step(1, 1, 1, 1, 0); step(1, 0, 1, 1, 0); idle(1);
        cap_en = 1;
        wait_empty();
        chk(!rd_valid, "R9", "no entry while disabled", rd_valid, 0);
        idle(3);
        dtag = "R9";
        step(0, 1, 1, 1, 1); idle(1);
        wait_empty();

        // R7 overflow without a reader
        drain = 0;
        for (int i = 0; i < 5; i++) step(1, 0, 1, 1, 0);
        step(1, 1, 1, 1, 0); step(1, 1, 1, 1, 1); step(1, 0, 1, 1, 0);
        idle(3);
        chk(wrapped == 1, "R7", "wrapped after overflow", wrapped, 1);
        drain = 1;
        wait_empty();
        chk(wrapped == 1, "R7", "wrapped stays set", wrapped, 1);

        // R10 clear empties buffer and resets the delta reference
        drain = 0;
        step(1, 0, 1, 1, 0); step(0, 1, 1, 1, 0); idle(3);
        clear = 1;
        @(posedge clk); #1;
        clear = 0;
        q.delete(); have_ref = 0;
        @(negedge clk);
        chk(!rd_valid, "R10", "empty after clear", rd_valid, 0);
        chk(!wrapped, "R10", "wrapped dropped by clear", wrapped, 0);
        idle(5);
        dtag = "R10";
        step(1, 0, 1, 1, 1); idle(1);
        drain = 1;
        wait_empty();
        chk(q.size() == 0, "R10", "post-clear entry delivered", q.size(), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule